// File: doc/BRIEF.md
# Three-Register Accumulator Processor Core

A small 8-bit processor core that fetches and executes a compact instruction set from an external memory. The core has three data registers. A can only be loaded from memory. B can be loaded from memory or with an immediate constant. C only ever receives arithmetic results. A separate compare instruction records how A relates to B in a test register. Six relational jumps read that test register, so the arithmetic path never sets any condition state.

Memory sits outside the core and is reached through one port. The port has an 8-bit address, separate write-data and read-data buses, and a read strobe and a write strobe. Read data is expected in the same cycle as the read strobe. A write is committed at the clock edge that closes the write cycle. Every access takes one clock. Reset restarts execution at address zero. A halt instruction stops the core until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the core presents address 0 with the read strobe high, the write strobe low and halted low. Registers A, B, C and the test register start at zero.
- R2: The opcode is bits 7:4 of the first instruction byte. Codes: 0 load A from memory, 1 load B from memory, 2 load B with a constant, 3 store B, 4 store C, 5 add, 6 subtract, 7 compare, 8 jump, 9 jump-if-equal, A jump-if-not-equal, B jump-if-greater, C jump-if-greater-or-equal, D jump-if-less, E jump-if-less-or-equal, F halt. Codes 0 to 4 and 8 to E take a second byte that holds the address or the constant. Codes 5, 6, 7 and F are one byte long.
- R3: Every memory access lasts one clock. The read strobe and the write strobe are never high together. The two bytes of an instruction are fetched in consecutive cycles.
- R4: Codes 0 and 1 load A and B from the addressed memory location. A changes only through code 0.
- R5: Code 2 loads the second instruction byte into B.
- R6: Code 3 writes B, and code 4 writes C, to the addressed memory location in a single write cycle.
- R7: Add sets C to (A+B) mod 256. Subtract sets C to (A-B) mod 256. Neither changes A or B. C changes only through these two instructions.
- R8: Compare sets the test register from an unsigned comparison of A with B, as three bits: equal, greater and less. At most one of these bits is ever set. The test register keeps its value until the next compare.
- R9: Code 8 always continues execution at the address held in its second byte.
- R10: The conditional jumps are taken under these conditions: code 9 on equal, code A on not-equal, code B on greater, code C on greater-or-equal, code D on less, code E on less-or-equal. When a jump is not taken, execution goes on at the next instruction. After reset with no compare executed, only code A is taken.
- R11: After the halt instruction the core raises halted and holds both strobes low. It stays in that state until reset.
- R12: The program counter advances by one for every instruction byte fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 8 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the cycle of the read strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| halted_o | output | 1 | Core stopped by the halt instruction |

## Verification
The bench builds the core with the default word width of 8. At that width the whole 256-byte address space fits in a bench array. An operand sweep that includes the wrap points 0, 1, 127, 128, 254 and 255 then reaches every sum and difference overflow case. For each A/B pair the bench runs all three orderings through all six relational jumps. A separate run with no compare checks the cleared test register just after reset.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LDA  = 4'h0, OP_LDB  = 4'h1, OP_LDBI = 4'h2, OP_STB  = 4'h3,
    OP_STC  = 4'h4, OP_ADD  = 4'h5, OP_SUB  = 4'h6, OP_CMP  = 4'h7,
    OP_JMP  = 4'h8, OP_JEQ  = 4'h9, OP_JNE  = 4'hA, OP_JGT  = 4'hB,
    OP_JGE  = 4'hC, OP_JLT  = 4'hD, OP_JLE  = 4'hE, OP_HALT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPND, ST_MEM, ST_EXEC, ST_HALT
  } state_e;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } test_t;

  function automatic logic has_operand(opcode_e op);
    return !(op inside {OP_ADD, OP_SUB, OP_CMP, OP_HALT});
  endfunction

  function automatic logic is_mem_op(opcode_e op);
    return op inside {OP_LDA, OP_LDB, OP_STB, OP_STC};
  endfunction
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output test_t        cmp_o
);
  logic [W-1:0] b_eff;

  assign b_eff     = sub_i ? ~b_i : b_i;
  assign res_o     = a_i + b_eff + W'(sub_i);
  assign cmp_o.eq  = (a_i == b_i);
  assign cmp_o.gt  = (a_i > b_i);
  assign cmp_o.lt  = (a_i < b_i);
endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
  import acc_cpu_pkg::*;
(
  input  opcode_e op_i,
  input  test_t   test_i,
  output logic    take_o
);
  always_comb begin
    unique case (op_i)
      OP_JMP:  take_o = 1'b1;
      OP_JEQ:  take_o = test_i.eq;
      OP_JNE:  take_o = !test_i.eq;
      OP_JGT:  take_o = test_i.gt;
      OP_JGE:  take_o = test_i.gt | test_i.eq;
      OP_JLT:  take_o = test_i.lt;
      OP_JLE:  take_o = test_i.lt | test_i.eq;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic [W-1:0] mem_rdata_i,
  output logic         mem_rd_o,
  output logic         mem_wr_o,
  output logic         halted_o
);
  localparam int OP_LSB = W - OP_W;

  state_e       st_q;
  logic [W-1:0] pc_q, ir_q, addr_q, a_q, b_q, c_q;
  test_t        test_q;

  opcode_e      op_ir, op_fetch;
  logic [W-1:0] alu_res;
  test_t        alu_cmp;
  logic         take;

  assign op_ir    = opcode_e'(ir_q[W-1:OP_LSB]);
  assign op_fetch = opcode_e'(mem_rdata_i[W-1:OP_LSB]);

  acc_cpu_alu #(.W(W)) i_alu (
    .a_i   (a_q),
    .b_i   (b_q),
    .sub_i (op_ir == OP_SUB),
    .res_o (alu_res),
    .cmp_o (alu_cmp)
  );

  acc_cpu_branch i_branch (
    .op_i   (op_ir),
    .test_i (test_q),
    .take_o (take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FETCH;
      pc_q   <= '0;
      ir_q   <= '0;
      addr_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      test_q <= '0;
    end else begin
      unique case (st_q)
        ST_FETCH: begin
          ir_q <= mem_rdata_i;
          pc_q <= pc_q + 1'b1;
          if (op_fetch == OP_HALT)        st_q <= ST_HALT;
          else if (has_operand(op_fetch)) st_q <= ST_OPND;
          else                            st_q <= ST_EXEC;
        end
        ST_OPND: begin
          pc_q <= pc_q + 1'b1;
          st_q <= ST_FETCH;
          if (is_mem_op(op_ir)) begin
            addr_q <= mem_rdata_i;
            st_q   <= ST_MEM;
          end else if (op_ir == OP_LDBI) begin
            b_q <= mem_rdata_i;
          end else if (take) begin
            pc_q <= mem_rdata_i;
          end
        end
        ST_MEM: begin
          if (op_ir == OP_LDA) a_q <= mem_rdata_i;
          if (op_ir == OP_LDB) b_q <= mem_rdata_i;
          st_q <= ST_FETCH;
        end
        ST_EXEC: begin
          if (op_ir == OP_CMP) test_q <= alu_cmp;
          else                 c_q    <= alu_res;
          st_q <= ST_FETCH;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    mem_addr_o  = (st_q == ST_MEM) ? addr_q : pc_q;
    mem_wdata_o = (op_ir == OP_STC) ? c_q : b_q;
    mem_rd_o    = (st_q == ST_FETCH) || (st_q == ST_OPND) ||
                  ((st_q == ST_MEM) && (op_ir inside {OP_LDA, OP_LDB}));
    mem_wr_o    = (st_q == ST_MEM) && (op_ir inside {OP_STB, OP_STC});
    halted_o    = (st_q == ST_HALT);
  end

  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_halt_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!mem_rd_o && !mem_wr_o));

  p_halt_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  p_a_mem_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((st_q == ST_MEM) && (op_ir == OP_LDA)) |=> $stable(a_q));

  p_c_alu_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((st_q == ST_EXEC) && (op_ir inside {OP_ADD, OP_SUB})) |=> $stable(c_q));

  p_pc_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH) |=> (pc_q == W'($past(pc_q) + 1'b1)));

  p_test_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(test_q));
endmodule

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic       mem_rd_o, mem_wr_o, halted_o;

  logic [7:0] mem [256];
  int total = 0;
  int bad = 0;
  int both_hi = 0;
  int wp = 0;

  always #5 clk_i = ~clk_i;

  acc_cpu_core i_acc_cpu_core (
    .clk_i, .rst_ni, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .mem_rd_o, .mem_wr_o, .halted_o
  );

  assign mem_rdata_i = mem[mem_addr_o];
  always @(posedge clk_i) if (rst_ni && mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  always @(negedge clk_i) if (mem_rd_o && mem_wr_o) both_hi++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int v);
    mem[wp[7:0]] = 8'(v);
    wp++;
  endtask

  // R2 encodings: cond k uses opcode 9+k; R5 code 2; R6 code 3 to 0xE2+k.
  task automatic emit_conds();
    for (int k = 0; k < 6; k++) begin
      int p = wp;
      put((9 + k) * 16); put(p + 8);
      put(8'h20); put(0); put(8'h30); put(8'hE2 + k);
      put(8'h80); put(p + 12);
      put(8'h20); put(1); put(8'h30); put(8'hE2 + k);
    end
  endtask

  task automatic prep();
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'hF0;
    for (int i = 8'hE0; i < 8'hF0; i++) mem[i] = 8'hAA;
    wp = 0;
  endtask

  task automatic run(input bit probe);
    @(negedge clk_i);
    rst_ni = 1'b1;
    if (probe) begin
      chk("R1 addr", mem_addr_o, 0);
      chk("R1 rd", mem_rd_o, 1);
      chk("R1 wr", mem_wr_o, 0);
      chk("R1 halted", halted_o, 0);
      @(negedge clk_i);
      chk("R12 second byte addr", mem_addr_o, 1);
      chk("R3 second byte rd", mem_rd_o, 1);
      @(negedge clk_i);
      chk("R3 data read addr", mem_addr_o, 8'hF0);
      chk("R3 data read strobe", {mem_rd_o, mem_wr_o}, 2);
    end
    for (int i = 0; i < 4000 && !halted_o; i++) @(negedge clk_i);
  endtask

  function automatic int exp_take(input int k, input int a, input int b);
    case (k)
      0: return int'(a == b);
      1: return int'(a != b);
      2: return int'(a > b);
      3: return int'(a >= b);
      4: return int'(a < b);
      default: return int'(a <= b);
    endcase
  endfunction

  function automatic int pick(input int i);
    case (i)
      0: return 0;   1: return 1;   2: return 2;   3: return 127;
      4: return 128; 5: return 200; 6: return 254; default: return 255;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=halted");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8/R10: test register cleared after reset, only not-equal is taken
    prep();
    emit_conds();
    put(8'hF0);
    repeat (2) @(negedge clk_i);
    chk("R1 reset addr", mem_addr_o, 0);
    chk("R1 reset rd", mem_rd_o, 1);
    run(1'b0);
    for (int k = 0; k < 6; k++)
      chk($sformatf("R10 no-compare cond %0d", k), mem[8'hE2 + k], int'(k == 1));

    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        int a = pick(ia);
        int b = pick(ib);
        int k2 = a ^ 8'h5A;
        prep();
        mem[8'hF0] = 8'(a);
        mem[8'hF1] = 8'(b);
        put(8'h00); put(8'hF0);   // R4 load A
        put(8'h10); put(8'hF1);   // R4 load B
        put(8'h50);               // add
        put(8'h40); put(8'hE0);   // R6 store C
        put(8'h60);               // sub
        put(8'h40); put(8'hE1);
        put(8'h70);               // compare
        emit_conds();
        put(8'h20); put(k2);      // R5 constant to B
        put(8'h30); put(8'hE8);
        put(8'hF0);
        run(ia == 0 && ib == 0);
        chk($sformatf("R7 add %0d+%0d", a, b), mem[8'hE0], (a + b) & 255);
        chk($sformatf("R7 sub %0d-%0d", a, b), mem[8'hE1], (a - b) & 255);
        chk("R5 R6 constant store", mem[8'hE8], k2);
        for (int k = 0; k < 6; k++)
          chk($sformatf("R9/R10 cond %0d a=%0d b=%0d", k, a, b),
              mem[8'hE2 + k], exp_take(k, a, b));
      end
    end

    // R11: halt is sticky and quiet
    chk("R11 halted", halted_o, 1);
    repeat (5) @(negedge clk_i);
    chk("R11 still halted", halted_o, 1);
    chk("R11 strobes low", {mem_rd_o, mem_wr_o}, 0);
    chk("R3 strobes never both high", both_hi, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule